// File: doc/BRIEF.md
# Multi-Cycle ALU with Overflow Register

This block carries out the two-operand arithmetic, bitwise and test operations of a small 16-bit processor. It also keeps that processor's overflow register. A sequencer outside the block presents a 4-bit operation code and two operand values, and pulses `start`. The block captures them, spends the architectural number of clock cycles for that operation, and then raises `done` for one cycle. With `done` it presents the value to write back, the new overflow value with its write enable, and a flag that tells the sequencer to skip the next instruction.

The overflow register is held inside the block and updated on the edge that raises `done`, when the operation produces an overflow value. Operand fetch, writeback and instruction sequencing belong to the surrounding core. While an operation is in flight, further `start` pulses are ignored.

Top module: `ovf_alu_core`

## Requirements
- R1: While `rst_n` is low, `done`, `a_we`, `ovf_we` and `skip_next` are 0 and `ovf_q` is 0; an operation in flight when reset arrives never completes.
- R2: Opcode 1 (copy) returns b, opcode 9 returns a AND b, opcode 10 returns a OR b and opcode 11 returns a XOR b. Each of these takes 1 cycle, asserts `a_we` and keeps `ovf_we` low.
- R3: Opcode 2 returns (a+b) mod 2^16 in 2 cycles and writes overflow 0x0001 on a carry out of bit 15, otherwise 0x0000.
- R4: Opcode 3 returns (a-b) mod 2^16 in 2 cycles and writes overflow 0xFFFF when b > a (unsigned), otherwise 0x0000.
- R5: Opcode 4 returns the low half of the 32-bit product a*b in 2 cycles and writes the high half to overflow.
- R6: Opcode 5 returns a/b and writes ((a<<16)/b) & 0xFFFF to overflow, both computed from the operand a as captured. When b is 0, both values are 0 and overflow is still written. It takes 3 cycles.
- R7: Opcode 6 returns a%b, or 0 when b is 0, in 3 cycles. It keeps `ovf_we` low and leaves `ovf_q` unchanged.
- R8: Opcode 7 returns (a<<b) & 0xFFFF and writes ((a<<b)>>16) & 0xFFFF. Opcode 8 returns a>>b and writes ((a<<16)>>b) & 0xFFFF. Both use a 32-bit intermediate, so a count of 16 or more gives a result of 0, and a count of 32 or more also gives an overflow of 0. Each takes 2 cycles.
- R9: Opcodes 12 (a==b), 13 (a!=b), 14 (unsigned a>b) and 15 ((a&b)!=0) keep `a_we` and `ovf_we` low. Each takes 2 cycles when the test holds. When the test fails, the operation takes 3 cycles and `skip_next` is raised with `done`.
- R10: `done` is a one-cycle pulse that rises exactly N rising edges after the edge that accepted `start`, where N is the cost of the operation. `res_a`, `ovf_next`, `a_we`, `ovf_we` and `skip_next` are valid while `done` is high, and `ovf_q` takes `ovf_next` on that same edge when `ovf_we` is set.
- R11: A `start` pulse that arrives while an operation is in flight is ignored. The running operation completes with its own operands and no extra `done` follows.
- R12: Opcode 0 is reserved. It takes 1 cycle and writes nothing: `a_we`, `ovf_we` and `skip_next` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| opcode | input | 4 | Operation code, captured with start |
| a_val | input | 16 | First operand value |
| b_val | input | 16 | Second operand value |
| res_a | output | 16 | Value to write back to the first operand |
| a_we | output | 1 | Write enable for res_a, valid with done |
| ovf_next | output | 16 | New overflow value, valid with done |
| ovf_we | output | 1 | Overflow write enable, valid with done |
| ovf_q | output | 16 | Current overflow register |
| skip_next | output | 1 | Skip the following instruction (failed test) |
| done | output | 1 | One-cycle completion strobe |

## Verification
The block's internal state is the captured operands, the cycle counter and the overflow register. A fault in any of them shows at the ports on the next `done`. A wrong counter load shows up as a `done` that arrives one or two edges early or late against the per-opcode cost. A stale or overwritten operand shows up in `res_a` or `ovf_next` of that same completion. A wrong overflow-register update shows up in `ovf_q` sampled right after that completion, and in the value carried into later operations that leave it alone. Faults in the busy guard show up as a second `done` within a few cycles of a `start` that was issued while busy.

// File: rtl/ovf_alu_pkg.sv
package ovf_alu_pkg;

   typedef enum logic [3:0] {
      OP_NOP = 4'h0,
      OP_MOV = 4'h1,
      OP_ADD = 4'h2,
      OP_SUB = 4'h3,
      OP_MUL = 4'h4,
      OP_DIV = 4'h5,
      OP_MOD = 4'h6,
      OP_SHL = 4'h7,
      OP_SHR = 4'h8,
      OP_AND = 4'h9,
      OP_ORR = 4'hA,
      OP_XOR = 4'hB,
      OP_CEQ = 4'hC,
      OP_CNE = 4'hD,
      OP_CGT = 4'hE,
      OP_CBT = 4'hF
   } alu_op_e;

   localparam int unsigned MAX_COST = 3;
   localparam int unsigned COST_W   = $clog2(MAX_COST + 1);

   function automatic logic is_test(input alu_op_e op);
      return (op == OP_CEQ) || (op == OP_CNE) || (op == OP_CGT) || (op == OP_CBT);
   endfunction

   // architectural cycle cost; a failed test pays one extra cycle
   function automatic logic [COST_W-1:0] op_cost(input alu_op_e op, input logic fail);
      logic [COST_W-1:0] c;
      unique case (op)
         OP_NOP, OP_MOV, OP_AND, OP_ORR, OP_XOR: c = COST_W'(1);
         OP_DIV, OP_MOD:                         c = COST_W'(3);
         OP_CEQ, OP_CNE, OP_CGT, OP_CBT:         c = fail ? COST_W'(3) : COST_W'(2);
         default:                                c = COST_W'(2);
      endcase
      return c;
   endfunction

endpackage

// File: rtl/ovf_alu_test.sv
module ovf_alu_test
   import ovf_alu_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  alu_op_e        op,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic           is_cmp,
   output logic           fail
);
   logic pass;

   always_comb begin
      unique case (op)
         OP_CEQ:  pass = (a == b);
         OP_CNE:  pass = (a != b);
         OP_CGT:  pass = (a > b);
         OP_CBT:  pass = |(a & b);
         default: pass = 1'b1;
      endcase
   end

   assign is_cmp = is_test(op);
   assign fail   = is_cmp & ~pass;
endmodule

// File: rtl/ovf_alu_datapath.sv
module ovf_alu_datapath
   import ovf_alu_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  alu_op_e        op,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [W-1:0]   res,
   output logic [W-1:0]   ovf,
   output logic           res_we,
   output logic           ovf_we
);
   localparam int unsigned DW = 2 * W;

   logic [W:0]    sum_w;
   logic [W:0]    dif_w;
   logic [DW-1:0] prod_w;
   logic [DW-1:0] quo_w;
   logic [W-1:0]  rem_w;
   logic [DW-1:0] shl_w;
   logic [DW-1:0] shr_w;
   logic          b_zero;

   assign b_zero = (b == '0);
   assign sum_w  = {1'b0, a} + {1'b0, b};
   assign dif_w  = {1'b0, a} - {1'b0, b};
   assign prod_w = DW'(a) * DW'(b);
   // one wide divide: top half is the quotient, bottom half the fraction
   assign quo_w  = b_zero ? '0 : ({a, {W{1'b0}}} / DW'(b));
   assign rem_w  = b_zero ? '0 : (a % b);
   assign shl_w  = DW'(a) << b;
   assign shr_w  = {a, {W{1'b0}}} >> b;

   always_comb begin
      res    = a;
      ovf    = '0;
      res_we = 1'b1;
      ovf_we = 1'b0;
      unique case (op)
         OP_MOV: res = b;
         OP_ADD: begin
            res    = sum_w[W-1:0];
            ovf    = W'(sum_w[W]);
            ovf_we = 1'b1;
         end
         OP_SUB: begin
            res    = dif_w[W-1:0];
            ovf    = {W{dif_w[W]}};
            ovf_we = 1'b1;
         end
         OP_MUL: begin
            res    = prod_w[W-1:0];
            ovf    = prod_w[DW-1:W];
            ovf_we = 1'b1;
         end
         OP_DIV: begin
            res    = quo_w[DW-1:W];
            ovf    = quo_w[W-1:0];
            ovf_we = 1'b1;
         end
         OP_MOD: res = rem_w;
         OP_SHL: begin
            res    = shl_w[W-1:0];
            ovf    = shl_w[DW-1:W];
            ovf_we = 1'b1;
         end
         OP_SHR: begin
            res    = shr_w[DW-1:W];
            ovf    = shr_w[W-1:0];
            ovf_we = 1'b1;
         end
         OP_AND: res = a & b;
         OP_ORR: res = a | b;
         OP_XOR: res = a ^ b;
         default: res_we = 1'b0;
      endcase
   end
endmodule

// File: rtl/ovf_alu_timer.sv
module ovf_alu_timer
   import ovf_alu_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [COST_W-1:0] cost,
   output logic              busy,
   output logic              fin
);
   logic [COST_W-1:0] remain_q;

   assign fin = busy && (remain_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         remain_q <= '0;
      end else if (load) begin
         busy     <= 1'b1;
         remain_q <= cost - COST_W'(1);
      end else if (fin) begin
         busy     <= 1'b0;
      end else if (busy) begin
         remain_q <= remain_q - COST_W'(1);
      end
   end
endmodule

// File: rtl/ovf_alu_core.sv
module ovf_alu_core
   import ovf_alu_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [3:0]    opcode,
   input  logic [W-1:0]  a_val,
   input  logic [W-1:0]  b_val,
   output logic [W-1:0]  res_a,
   output logic          a_we,
   output logic [W-1:0]  ovf_next,
   output logic          ovf_we,
   output logic [W-1:0]  ovf_q,
   output logic          skip_next,
   output logic          done
);
   generate
      if (W < 2) begin : g_bad_width
         $error("ovf_alu_core: W must be at least 2");
      end
   endgenerate

   alu_op_e       op_in;
   alu_op_e       op_q;
   logic [W-1:0]  a_q;
   logic [W-1:0]  b_q;
   logic          skip_q;
   logic          accept;
   logic          busy;
   logic          fin;
   logic          in_cmp;
   logic          in_fail;
   logic [W-1:0]  dp_res;
   logic [W-1:0]  dp_ovf;
   logic          dp_rwe;
   logic          dp_owe;

   assign op_in  = alu_op_e'(opcode);
   assign accept = start && !busy;

   ovf_alu_test #(.W(W)) u_test (
      .op     (op_in),
      .a      (a_val),
      .b      (b_val),
      .is_cmp (in_cmp),
      .fail   (in_fail)
   );

   ovf_alu_timer u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept),
      .cost  (op_cost(op_in, in_fail)),
      .busy  (busy),
      .fin   (fin)
   );

   ovf_alu_datapath #(.W(W)) u_dp (
      .op     (op_q),
      .a      (a_q),
      .b      (b_q),
      .res    (dp_res),
      .ovf    (dp_ovf),
      .res_we (dp_rwe),
      .ovf_we (dp_owe)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= OP_NOP;
         a_q    <= '0;
         b_q    <= '0;
         skip_q <= 1'b0;
      end else if (accept) begin
         op_q   <= op_in;
         a_q    <= a_val;
         b_q    <= b_val;
         skip_q <= in_cmp & in_fail;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_a     <= '0;
         ovf_next  <= '0;
         a_we      <= 1'b0;
         ovf_we    <= 1'b0;
         skip_next <= 1'b0;
         done      <= 1'b0;
         ovf_q     <= '0;
      end else begin
         done      <= fin;
         a_we      <= fin & dp_rwe;
         ovf_we    <= fin & dp_owe;
         skip_next <= fin & skip_q;
         if (fin) begin
            res_a    <= dp_res;
            ovf_next <= dp_ovf;
            if (dp_owe) ovf_q <= dp_ovf;
         end
      end
   end
endmodule

// File: rtl/ovf_alu_chk.sv
module ovf_alu_chk #(
   parameter int unsigned W = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          busy,
   input logic          done,
   input logic          a_we,
   input logic          ovf_we,
   input logic          skip_next,
   input logic [W-1:0]  ovf_q
);
   logic [2:0] lat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                lat_q <= '0;
      else if (start && !busy)   lat_q <= '0;
      else if (busy && lat_q != 3'd7) lat_q <= lat_q + 3'd1;
   end

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lat_q >= 3'd1 && lat_q <= 3'd3));
   p_owe_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_we |-> done);
   p_awe_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      a_we |-> done);
   p_skip_cost_r9: assert property (@(posedge clk) disable iff (!rst_n)
      skip_next |-> (done && !a_we && !ovf_we && lat_q == 3'd3));
   p_ovf_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ovf_q) |-> (done && ovf_we));
endmodule

bind ovf_alu_core ovf_alu_chk #(.W(W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .done      (done),
   .a_we      (a_we),
   .ovf_we    (ovf_we),
   .skip_next (skip_next),
   .ovf_q     (ovf_q)
);

// File: tb/tb_ovf_alu_core.sv
module tb_ovf_alu_core;
   localparam int unsigned W        = 16;
   localparam time         CLK_PER  = 10ns;
   localparam int          NVEC     = 25;

   typedef struct packed {
      logic [3:0]  op;
      logic [15:0] a;
      logic [15:0] b;
      logic [15:0] res;
      logic [15:0] ovf;
      logic        awe;
      logic        owe;
      logic        skip;
      logic [1:0]  cyc;
   } vec_t;

   localparam vec_t VECS [NVEC] = '{
      '{4'h1, 16'h1234, 16'hABCD, 16'hABCD, 16'h0000, 1'b1, 1'b0, 1'b0, 2'd1}, // R2 copy
      '{4'h2, 16'hFFFF, 16'h0002, 16'h0001, 16'h0001, 1'b1, 1'b1, 1'b0, 2'd2}, // R3 carry
      '{4'h2, 16'h1000, 16'h2000, 16'h3000, 16'h0000, 1'b1, 1'b1, 1'b0, 2'd2}, // R3 no carry
      '{4'h3, 16'h0001, 16'h0002, 16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 1'b0, 2'd2}, // R4 borrow
      '{4'h4, 16'h1234, 16'h0100, 16'h3400, 16'h0012, 1'b1, 1'b1, 1'b0, 2'd2}, // R5
      '{4'h5, 16'h0007, 16'h0002, 16'h0003, 16'h8000, 1'b1, 1'b1, 1'b0, 2'd3}, // R6
      '{4'h5, 16'h0005, 16'h0000, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b0, 2'd3}, // R6 b=0
      '{4'h2, 16'hFFFF, 16'h0001, 16'h0000, 16'h0001, 1'b1, 1'b1, 1'b0, 2'd2}, // R3 O=1 before MOD
      '{4'h6, 16'h0007, 16'h0003, 16'h0001, 16'h0000, 1'b1, 1'b0, 1'b0, 2'd3}, // R7
      '{4'h6, 16'h0009, 16'h0000, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b0, 2'd3}, // R7 b=0
      '{4'h7, 16'h8001, 16'h0004, 16'h0010, 16'h0008, 1'b1, 1'b1, 1'b0, 2'd2}, // R8 shl
      '{4'h7, 16'h1234, 16'h0014, 16'h0000, 16'h2340, 1'b1, 1'b1, 1'b0, 2'd2}, // R8 shl 20
      '{4'h8, 16'h1234, 16'h0004, 16'h0123, 16'h4000, 1'b1, 1'b1, 1'b0, 2'd2}, // R8 shr
      '{4'h8, 16'h1234, 16'h0010, 16'h0000, 16'h1234, 1'b1, 1'b1, 1'b0, 2'd2}, // R8 shr 16
      '{4'h9, 16'hF0F0, 16'h3C3C, 16'h3030, 16'h0000, 1'b1, 1'b0, 1'b0, 2'd1}, // R2 and
      '{4'hA, 16'hF0F0, 16'h0F00, 16'hFFF0, 16'h0000, 1'b1, 1'b0, 1'b0, 2'd1}, // R2 or
      '{4'hB, 16'hFFFF, 16'h00FF, 16'hFF00, 16'h0000, 1'b1, 1'b0, 1'b0, 2'd1}, // R2 xor
      '{4'hC, 16'h0005, 16'h0005, 16'h0005, 16'h0000, 1'b0, 1'b0, 1'b0, 2'd2}, // R9
      '{4'hC, 16'h0005, 16'h0006, 16'h0005, 16'h0000, 1'b0, 1'b0, 1'b1, 2'd3}, // R9
      '{4'hD, 16'h0005, 16'h0006, 16'h0005, 16'h0000, 1'b0, 1'b0, 1'b0, 2'd2}, // R9
      '{4'hD, 16'h0005, 16'h0005, 16'h0005, 16'h0000, 1'b0, 1'b0, 1'b1, 2'd3}, // R9
      '{4'hE, 16'h8000, 16'h7FFF, 16'h8000, 16'h0000, 1'b0, 1'b0, 1'b0, 2'd2}, // R9 unsigned
      '{4'hE, 16'h7FFF, 16'h8000, 16'h7FFF, 16'h0000, 1'b0, 1'b0, 1'b1, 2'd3}, // R9
      '{4'hF, 16'h00F0, 16'h0F00, 16'h00F0, 16'h0000, 1'b0, 1'b0, 1'b1, 2'd3}, // R9
      '{4'h0, 16'h4321, 16'h1111, 16'h4321, 16'h0000, 1'b0, 1'b0, 1'b0, 2'd1}  // R12
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [3:0]    opcode = '0;
   logic [W-1:0]  a_val = '0;
   logic [W-1:0]  b_val = '0;
   logic [W-1:0]  res_a;
   logic          a_we;
   logic [W-1:0]  ovf_next;
   logic          ovf_we;
   logic [W-1:0]  ovf_q;
   logic          skip_next;
   logic          done;

   int n_chk = 0;
   int n_bad = 0;
   logic [W-1:0] o_model = '0;

   always #(CLK_PER/2) clk = ~clk;

   ovf_alu_core #(.W(W)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
      .a_val(a_val), .b_val(b_val), .res_a(res_a), .a_we(a_we),
      .ovf_next(ovf_next), .ovf_we(ovf_we), .ovf_q(ovf_q),
      .skip_next(skip_next), .done(done)
   );

   task automatic chk(input string rq, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   // issue one operation, return cycles from accepting edge to visible done
   task automatic run_op(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b,
                         output int cyc);
      @(negedge clk);
      opcode = op; a_val = a; b_val = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      while (!done && cyc < 8) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL R10 watchdog expired: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int cyc;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "done", done, 0);
      chk("R1", "ovf_q", ovf_q, 0);
      chk("R1", "skip_next", skip_next, 0);
      chk("R1", "ovf_we", ovf_we, 0);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         vec_t v;
         string rq;
         v = VECS[i];
         case (v.op)
            4'h0: rq = "R12";
            4'h1, 4'h9, 4'hA, 4'hB: rq = "R2";
            4'h2: rq = "R3";
            4'h3: rq = "R4";
            4'h4: rq = "R5";
            4'h5: rq = "R6";
            4'h6: rq = "R7";
            4'h7, 4'h8: rq = "R8";
            default: rq = "R9";
         endcase
         run_op(v.op, v.a, v.b, cyc);
         chk("R10", "cycles", cyc, int'(v.cyc));
         chk(rq, "a_we", a_we, v.awe);
         if (v.awe) chk(rq, "res_a", res_a, v.res);
         chk(rq, "ovf_we", ovf_we, v.owe);
         if (v.owe) begin
            chk(rq, "ovf_next", ovf_next, v.ovf);
            o_model = v.ovf;
         end
         chk(rq, "skip_next", skip_next, v.skip);
         chk(rq, "ovf_q", ovf_q, o_model);
         @(negedge clk);
         chk("R10", "done pulse width", done, 0);
      end

      // R11: start while busy is ignored
      @(negedge clk);
      opcode = 4'h5; a_val = 16'h0007; b_val = 16'h0002; start = 1'b1;
      @(negedge clk);
      opcode = 4'h1; b_val = 16'h5555;
      cyc = 0;
      while (!done && cyc < 8) begin
         @(negedge clk);
         cyc++;
      end
      start = 1'b0;
      chk("R11", "cycles", cyc, 3);
      chk("R11", "res_a", res_a, 16'h0003);
      begin
         int extra = 0;
         for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (done) extra++;
         end
         chk("R11", "extra done", extra, 0);
      end

      // R1: reset in flight clears O and cancels the operation
      chk("R1", "ovf_q before reset", ovf_q, 16'h8000);
      @(negedge clk);
      opcode = 4'h4; a_val = 16'hFFFF; b_val = 16'hFFFF; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1", "ovf_q in reset", ovf_q, 0);
      chk("R1", "done in reset", done, 0);
      rst_n = 1'b1;
      begin
         int extra = 0;
         for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (done) extra++;
         end
         chk("R1", "cancelled done", extra, 0);
      end

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule